// File: doc/BRIEF.md
# Pin Interrupt Edge/Level Unit

An eight-channel interrupt front end for general-purpose input pins. Each channel watches one input that has already been routed to it. A two-stage synchroniser brings the input into the clock domain. The channel then raises a request either on selected edges or for as long as the input sits at a chosen level. Each channel drives its own request line toward an interrupt controller.

Software sets the unit up through a small single-port register interface. Each register holds one bit per channel, with bit n belonging to channel n. There is a mode register and two enable registers, one for falling edges and one for rising edges. Each enable register has a write-one-to-set alias and a write-one-to-clear alias. A status register records edge hits and is cleared by writing ones to it.

In level mode the two enable registers take on new roles. The falling-enable bit chooses the active level, and the rising-enable bit switches the level request on or off.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, every register reads zero and every request line is low. Zero in the falling-enable register means falling edges are off and the active level is LOW.
- R2: The register select on `bus_addr` is: 0 mode, 1 falling enable, 2 falling-enable set alias, 3 falling-enable clear alias, 4 rising enable, 5 rising-enable set alias, 6 rising-enable clear alias, 7 edge status. In the mode register, a 0 in bit n puts channel n in edge mode and a 1 puts it in level mode.
- R3: In edge mode with rising-enable bit n set, a rising edge on `pin_in[n]` sets status bit n. `irq_o[n]` goes high after the third rising clock edge that follows the pin change.
- R4: In edge mode with falling-enable bit n set, a falling edge on `pin_in[n]` sets status bit n.
- R5: An edge whose enable bit is 0 does not set the status bit.
- R6: Writing 1 to status bit n clears it, and writing 0 leaves it unchanged. If a new enabled edge is detected in the same cycle as the clear, the status bit stays set.
- R7: In level mode, `irq_o[n]` is high exactly when rising-enable bit n is 1 and the synchronised pin equals the level chosen by falling-enable bit n (1 selects HIGH, 0 selects LOW). It follows a pin change after the second rising clock edge. Level mode never sets the status bit.
- R8: Writing 1 to bit n of a set alias (address 2 or 5) sets bit n of the matching enable register, and writing 0 has no effect. The set aliases read as zero.
- R9: Writing 1 to bit n of a clear alias (address 3 or 6) clears bit n of the matching enable register, and writing 0 has no effect. The clear aliases read as zero. In level mode, clearing a falling-enable bit selects LOW-active.
- R10: Bits 31:8 of every register read as zero, and writes to those bits have no effect.
- R11: In edge mode, `irq_o[n]` equals status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Asynchronous channel inputs |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 8 | Per-channel interrupt requests |

## Verification
The bench uses the default parameters: eight channels, a 32-bit data bus and two synchroniser stages. With these values, the three-cycle edge latency and the two-cycle level latency can be checked cycle by cycle. The reserved bits 31:8 can also be written and read back. The random part mixes writes to all eight addresses with pin changes, so mode switches, alias writes and status clears occur while edges are pending. A directed case places a status clear in the same cycle as an edge detection.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [2:0] {
    RS_MODE     = 3'd0,
    RS_FALL     = 3'd1,
    RS_FALL_SET = 3'd2,
    RS_FALL_CLR = 3'd3,
    RS_RISE     = 3'd4,
    RS_RISE_SET = 3'd5,
    RS_RISE_CLR = 3'd6,
    RS_STATUS   = 3'd7
  } reg_sel_e;

  // Level request: enabled and pin at the chosen level (hi_sel=1 -> HIGH)
  function automatic logic level_req(logic pin, logic hi_sel, logic en);
    return en & (hi_sel ? pin : ~pin);
  endfunction

  // Edge hit: any detected edge whose enable is on
  function automatic logic edge_req(logic rise, logic fall,
                                    logic rise_en, logic fall_en);
    return (rise & rise_en) | (fall & fall_en);
  endfunction

  // Next value of one enable bit; set alias wins over clear alias
  function automatic logic en_next(logic cur, logic wr_plain, logic wr_set,
                                   logic wr_clr, logic d);
    logic nxt;
    nxt = cur;
    if (wr_plain)        nxt = d;
    else if (wr_set & d) nxt = 1'b1;
    else if (wr_clr & d) nxt = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_raw,
  output logic [N_CH-1:0] pin_s,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_CH-1:0] st_q [SYNC_STAGES];
  logic [N_CH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) st_q[k] <= '0;
      prev_q <= '0;
    end else begin
      st_q[0] <= pin_raw;
      for (int k = 1; k < SYNC_STAGES; k++) st_q[k] <= st_q[k-1];
      prev_q <= st_q[LAST];
    end
  end

  assign pin_s  = st_q[LAST];
  assign rise_o = pin_s & ~prev_q;
  assign fall_o = ~pin_s & prev_q;

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_CH-1:0]   stat_q,
  output logic [N_CH-1:0]   mode_q,
  output logic [N_CH-1:0]   fall_q,
  output logic [N_CH-1:0]   rise_q,
  output logic [N_CH-1:0]   stat_clr,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e        sel;
  logic [N_CH-1:0] wd;
  logic [N_CH-1:0] fall_d, rise_d;
  logic            unused_hi;

  assign sel       = reg_sel_e'(addr);
  assign wd        = wdata[N_CH-1:0];
  assign unused_hi = ^wdata[DATA_W-1:N_CH];

  logic wr_mode, wr_fall, wr_fall_set, wr_fall_clr;
  logic wr_rise, wr_rise_set, wr_rise_clr, wr_stat;
  assign wr_mode     = we && sel == RS_MODE;
  assign wr_fall     = we && sel == RS_FALL;
  assign wr_fall_set = we && sel == RS_FALL_SET;
  assign wr_fall_clr = we && sel == RS_FALL_CLR;
  assign wr_rise     = we && sel == RS_RISE;
  assign wr_rise_set = we && sel == RS_RISE_SET;
  assign wr_rise_clr = we && sel == RS_RISE_CLR;
  assign wr_stat     = we && sel == RS_STATUS;

  for (genvar b = 0; b < N_CH; b++) begin : g_bit
    assign fall_d[b] = en_next(fall_q[b], wr_fall, wr_fall_set, wr_fall_clr, wd[b]);
    assign rise_d[b] = en_next(rise_q[b], wr_rise, wr_rise_set, wr_rise_clr, wd[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wd;
      fall_q <= fall_d;
      rise_q <= rise_d;
    end
  end

  assign stat_clr = wr_stat ? wd : '0;

  always_comb begin
    rdata = '0;
    case (sel)
      RS_MODE:   rdata[N_CH-1:0] = mode_q;
      RS_FALL:   rdata[N_CH-1:0] = fall_q;
      RS_RISE:   rdata[N_CH-1:0] = rise_q;
      RS_STATUS: rdata[N_CH-1:0] = stat_q;
      default:   rdata = '0;
    endcase
  end

  // R8
  fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall_set |=> ((fall_q & $past(wd)) == $past(wd)));
  // R8
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise_set |=> ((rise_q & $past(wd)) == $past(wd)));
  // R9
  fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall_clr |=> ((fall_q & $past(wd)) == '0));
  // R9
  rise_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise_clr |=> ((rise_q & $past(wd)) == '0));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic fall_en,
  input  logic rise_en,
  input  logic pin_s,
  input  logic rise,
  input  logic fall,
  input  logic clr,
  output logic stat_q,
  output logic irq
);
  logic edge_set;

  assign edge_set = !mode && edge_req(rise, fall, rise_en, fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= 1'b0;
    else if (edge_set) stat_q <= 1'b1;
    else if (clr)      stat_q <= 1'b0;
  end

  assign irq = mode ? level_req(pin_s, fall_en, rise_en) : stat_q;

  // R3 R4 R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_set |=> stat_q);
  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_set) |=> !stat_q);
  // R5 R7
  no_spurious_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_set |=> !$rose(stat_q));
  // R7
  level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !rise_en) |-> !irq);

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   pin_in,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0] pin_s, rise, fall;
  logic [N_CH-1:0] mode_q, fall_q, rise_q, stat_q, stat_clr;

  pin_irq_sync #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
    .pin_s(pin_s), .rise_o(rise), .fall_o(fall)
  );

  pin_irq_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .stat_q(stat_q), .mode_q(mode_q),
    .fall_q(fall_q), .rise_q(rise_q), .stat_clr(stat_clr),
    .rdata(bus_rdata)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pin_irq_chan u_ch (
      .clk(clk), .rst_n(rst_n), .mode(mode_q[c]), .fall_en(fall_q[c]),
      .rise_en(rise_q[c]), .pin_s(pin_s[c]), .rise(rise[c]),
      .fall(fall[c]), .clr(stat_clr[c]), .stat_q(stat_q[c]),
      .irq(irq_o[c])
    );
  end

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N_CH] == '0);
  // R11
  edge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~mode_q) == (stat_q & ~mode_q)));

endmodule

// File: tb/sim_pin_irq_unit.sv
`timescale 1ns/1ps
module sim_pin_irq_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  pin_in = '0;
  logic        bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  pin_irq_unit u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_mode = 0, m_fall = 0, m_rise = 0, m_stat = 0, m_pin = 0;

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int b = 0; b < 8; b++)
      r[b] = m_mode[b] ? (m_rise[b] && (m_pin[b] == m_fall[b])) : m_stat[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {24'h0, m_mode};
      3'd1: return {24'h0, m_fall};
      3'd4: return {24'h0, m_rise};
      3'd7: return {24'h0, m_stat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    case (a)
      3'd0: m_mode = d[7:0];
      3'd1: m_fall = d[7:0];
      3'd2: m_fall |= d[7:0];
      3'd3: m_fall &= ~d[7:0];
      3'd4: m_rise = d[7:0];
      3'd5: m_rise |= d[7:0];
      3'd6: m_rise &= ~d[7:0];
      default: m_stat &= ~d[7:0];
    endcase
  endtask

  task automatic rd_check(string req, logic [2:0] a);
    bus_addr = a; #0.5;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic drive_pins(logic [7:0] v);
    @(negedge clk);
    m_stat |= ~m_mode & ((~m_pin & v & m_rise) | (m_pin & ~v & m_fall));
    m_pin = v; pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {24'h0, irq_o}, 32'h0);
    for (int a = 0; a < 8; a++) rd_check("R1 read", 3'(a));

    // R8 set alias, R10 reserved bits ignored
    wr(3'd5, 32'hFFFF_FF0F);
    rd_check("R8 rise set", 3'd4);
    rd_check("R8 set alias reads zero", 3'd5);
    wr(3'd2, 32'h0000_00F0);
    rd_check("R8 fall set", 3'd1);
    wr(3'd0, 32'hFFFF_FF00);
    rd_check("R10 mode upper ignored", 3'd0);
    // R9 clear alias
    wr(3'd6, 32'h0000_000C);
    rd_check("R9 rise clear", 3'd4);
    rd_check("R9 clear alias reads zero", 3'd6);

    // R3 edge latency: channel 0 rising, edge mode, rise enabled
    @(negedge clk); pin_in[0] = 1'b1;
    m_stat |= ~m_mode & 8'h01 & m_rise; m_pin[0] = 1'b1;
    @(negedge clk); check("R3 irq after 1 clk", {31'h0, irq_o[0]}, 32'h0);
    @(negedge clk); check("R3 irq after 2 clk", {31'h0, irq_o[0]}, 32'h0);
    @(negedge clk); check("R3 irq after 3 clk", {31'h0, irq_o[0]}, 32'h1);
    rd_check("R3 status", 3'd7);
    check("R11 irq equals status", {24'h0, irq_o}, {24'h0, m_stat});
    // R6 writing zero leaves status
    wr(3'd7, 32'h0000_00FE);
    rd_check("R6 zero write keeps", 3'd7);
    wr(3'd7, 32'h0000_0001);
    rd_check("R6 clear", 3'd7);
    check("R6 irq cleared", {24'h0, irq_o}, {24'h0, exp_irq()});

    // R4 falling edge with fall enable (ch4), R5 disabled (ch2)
    drive_pins(8'h15);
    wr(3'd7, 32'hFF);
    drive_pins(8'h01);
    rd_check("R4/R5 status after falls", 3'd7);
    check("R4 irq", {24'h0, irq_o}, {24'h0, exp_irq()});
    wr(3'd7, 32'hFF);

    // R6 collision: clear in same cycle as new edge on ch1
    @(negedge clk); pin_in[1] = 1'b1; m_pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 3'd7; bus_wdata = 32'h02;
    @(negedge clk); bus_we = 0;
    m_stat[1] = 1'b1;
    rd_check("R6 edge wins over clear", 3'd7);
    wr(3'd7, 32'hFF);

    // R7 level mode, ch3: enable, HIGH-active, latency 2
    wr(3'd0, 32'h08);
    wr(3'd5, 32'h08);
    wr(3'd2, 32'h08);
    @(negedge clk); pin_in[3] = 1'b1; m_pin[3] = 1'b1;
    @(negedge clk); check("R7 level after 1 clk", {31'h0, irq_o[3]}, 32'h0);
    @(negedge clk); check("R7 level after 2 clk", {31'h0, irq_o[3]}, 32'h1);
    rd_check("R7 level sets no status", 3'd7);
    // R9 clear selects LOW-active
    wr(3'd3, 32'h08);
    check("R9 LOW-active now idle", {31'h0, irq_o[3]}, 32'h0);
    drive_pins(m_pin & ~8'h08);
    check("R7 LOW-active asserted", {31'h0, irq_o[3]}, 32'h1);
    wr(3'd6, 32'h08);
    check("R7 master enable off", {31'h0, irq_o[3]}, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 3;
      if (op == 0) drive_pins(8'($urandom));
      else wr(3'($urandom), $urandom);
      check("R3/R4/R7/R11 random irq", {24'h0, irq_o}, {24'h0, exp_irq()});
      rd_check("R2/R10 random read", 3'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule